// File: doc/BRIEF.md
# Hall Commutation Gate Selector

This block turns the state of three rotor-position sensors, placed 120 electrical degrees apart, into on/off commands for the six gate drivers of a three-phase bridge (a high-side and a low-side switch per phase A, B and C). A direction input picks which of two phase pairings each sensor code selects. The chosen pair is then reshaped by the current chopper's on/off qualifier: during the off interval the decay-mode and synchronous-rectification inputs decide which switches, if any, keep conducting.

Three override inputs sit above the commutation result. A disable input turns every switch off and clears the invalid-sensor flag. A coast request from the fault supervisor turns every switch off. An active-low brake input turns on the three low-side switches and turns off the three high-side switches. The sensor inputs are asynchronous, so they pass through a synchronizer first, and a one-cycle strobe marks every change in the synchronized code. Electrical gate drive and dead-time insertion are handled outside this block.

Top module: `hall_gate_sel`

## Requirements
- R1: `hall_in` passes through a two-flop synchronizer. If a new value is sampled at clock edge n, `hall_edge` is high for the single cycle that follows edge n+1, and the gate outputs show the new code from edge n+2 on. Changes on any other input take effect at the next clock edge.
- R2: With `dir_fwd`=1 and `pwm_on`=1, the code {hall_in[2],hall_in[1],hall_in[0]} selects exactly one high side and one low side, written as bit 0=A, 1=B, 2=C: 101 gives high A and low C, 100 gives high B and low C, 110 gives high B and low A, 010 gives high C and low A, 011 gives high C and low B, 001 gives high A and low B.
- R3: With `dir_fwd`=0, every code selects the R2 pair with the roles exchanged: the R2 low-side phase becomes the high side, and the R2 high-side phase becomes the low side.
- R4: Codes 000 and 111 turn all six gates off and raise `hall_bad`, even when braking. When no disable is active, `hall_bad` is low for every other code.
- R5: With `pwm_on`=0, `decay_slow`=1 and `sync_rect`=0, only the selected low side stays on.
- R6: With `pwm_on`=0, `decay_slow`=0 and `sync_rect`=0, all gates are off.
- R7: With `pwm_on`=0, `decay_slow`=0 and `sync_rect`=1, the complementary pair conducts: the high side of the selected low-side phase and the low side of the selected high-side phase.
- R8: With `pwm_on`=0, `decay_slow`=1 and `sync_rect`=1, the low sides of both selected phases are on and no high side is on.
- R9: With a valid code and `brake_n`=0, all three low sides are on and all high sides are off, whatever `pwm_on`, `decay_slow` and `sync_rect` are.
- R10: `coast_req`=1 turns all gates off. It overrides braking and commutation.
- R11: `drv_off`=1 turns all gates off and forces `hall_bad` low. It overrides every other input.
- R12: While `rst` is high, all outputs are low.
- R13: At any time at most one high side is on, and no phase has its high side and low side on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 3 | Asynchronous sensor levels, bit 2 first sensor |
| dir_fwd | input | 1 | Rotation direction select |
| decay_slow | input | 1 | 1 = slow decay, 0 = fast decay |
| sync_rect | input | 1 | Synchronous rectification enable |
| brake_n | input | 1 | Active-low dynamic brake |
| drv_off | input | 1 | Disable: all gates off, invalid flag cleared |
| pwm_on | input | 1 | Chopper on-interval qualifier |
| coast_req | input | 1 | Fault supervisor coast request |
| gate_hi | output | 3 | High-side enables, bit 0=A, 1=B, 2=C |
| gate_lo | output | 3 | Low-side enables, bit 0=A, 1=B, 2=C |
| hall_bad | output | 1 | Illegal sensor code present |
| hall_edge | output | 1 | One-cycle strobe on a synchronized code change |

## Verification
The bench targets four kinds of error. The first is the exact latency split between the change strobe and the gate update: a design with one synchronizer stage too few or too many would move both by a cycle. The second is codes that change on consecutive cycles, where a strobe built as a pulse stretcher would merge the changes. The third is the four chop-off variants under both directions: a swapped complement or a mode decode that inverts the sense of `decay_slow` shows up as the wrong phase conducting. The fourth is the override order. Braking on an illegal code, coasting while braking, and disabling with an illegal code each expose a priority inversion, either as low sides turning on during a fault or as a stuck `hall_bad`.

// File: rtl/hgs_pkg.sv
package hgs_pkg;

    localparam int NUM_PH = 3;
    localparam int HALL_W = 3;

    typedef enum logic [1:0] {
        PH_A    = 2'd0,
        PH_B    = 2'd1,
        PH_C    = 2'd2,
        PH_NONE = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        CHOP_FAST_OPEN = 2'b00,
        CHOP_FAST_SR   = 2'b01,
        CHOP_SLOW_OPEN = 2'b10,
        CHOP_SLOW_SR   = 2'b11
    } chop_e;

    typedef struct packed {
        phase_e src;
        phase_e snk;
        logic   valid;
    } step_t;

    typedef struct packed {
        logic [NUM_PH-1:0] hi;
        logic [NUM_PH-1:0] lo;
    } gates_t;

    function automatic logic [NUM_PH-1:0] ph_mask(phase_e p);
        logic [NUM_PH-1:0] m;
        m = '0;
        if (p != PH_NONE) m[int'(p)] = 1'b1;
        return m;
    endfunction

    // forward pairing; reverse exchanges source and sink
    function automatic step_t step_lookup(logic [HALL_W-1:0] code, logic fwd);
        step_t s;
        s.valid = 1'b1;
        case (code)
            3'b101:  begin s.src = PH_A; s.snk = PH_C; end
            3'b100:  begin s.src = PH_B; s.snk = PH_C; end
            3'b110:  begin s.src = PH_B; s.snk = PH_A; end
            3'b010:  begin s.src = PH_C; s.snk = PH_A; end
            3'b011:  begin s.src = PH_C; s.snk = PH_B; end
            3'b001:  begin s.src = PH_A; s.snk = PH_B; end
            default: begin s.src = PH_NONE; s.snk = PH_NONE; s.valid = 1'b0; end
        endcase
        if (!fwd) begin
            phase_e t;
            t     = s.src;
            s.src = s.snk;
            s.snk = t;
        end
        return s;
    endfunction

endpackage

// File: rtl/hgs_hall_sync.sv
module hgs_hall_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] code,
    output logic         change
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            prev_q <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev_q <= stg[LAST];
        end
    end

    assign code   = stg[LAST];
    assign change = (stg[LAST] != prev_q);

    // R1
    edge_after_move_chk: assert property (@(posedge clk) disable iff (rst)
        change |=> (prev_q == $past(code)));

endmodule

// File: rtl/hgs_step_decode.sv
module hgs_step_decode
    import hgs_pkg::*;
(
    input  logic [HALL_W-1:0] code,
    input  logic              fwd,
    output step_t             step
);
    always_comb begin
        step = step_lookup(code, fwd);
    end
endmodule

// File: rtl/hgs_gate_mux.sv
module hgs_gate_mux
    import hgs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  step_t  step,
    input  logic   decay_slow,
    input  logic   sync_rect,
    input  logic   brake_n,
    input  logic   drv_off,
    input  logic   pwm_on,
    input  logic   coast_req,
    output gates_t g_q,
    output logic   bad_q
);
    gates_t            g_n;
    logic              bad_n;
    logic [NUM_PH-1:0] src_m;
    logic [NUM_PH-1:0] snk_m;
    chop_e             chop;

    always_comb begin
        src_m = ph_mask(step.src);
        snk_m = ph_mask(step.snk);
        chop  = chop_e'({decay_slow, sync_rect});
        g_n   = '0;
        bad_n = !step.valid;
        if (drv_off) begin
            bad_n = 1'b0;
        end else if (coast_req || !step.valid) begin
            g_n = '0;
        end else if (!brake_n) begin
            g_n.lo = '1;
        end else if (pwm_on) begin
            g_n.hi = src_m;
            g_n.lo = snk_m;
        end else begin
            case (chop)
                CHOP_SLOW_OPEN: g_n.lo = snk_m;
                CHOP_FAST_SR:   begin g_n.hi = snk_m; g_n.lo = src_m; end
                CHOP_SLOW_SR:   g_n.lo = src_m | snk_m;
                default:        g_n = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q   <= '0;
            bad_q <= 1'b0;
        end else begin
            g_q   <= g_n;
            bad_q <= bad_n;
        end
    end

    // R13
    no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
        (g_q.hi & g_q.lo) == '0);

    // R13
    single_high_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(g_q.hi));

    // R11
    disable_off_chk: assert property (@(posedge clk) disable iff (rst)
        drv_off |=> (g_q == '0 && !bad_q));

    // R10
    coast_off_chk: assert property (@(posedge clk) disable iff (rst)
        coast_req |=> (g_q == '0));

    // R9
    brake_lows_chk: assert property (@(posedge clk) disable iff (rst)
        (!brake_n && !coast_req && !drv_off && step.valid) |=>
            (g_q.lo == '1 && g_q.hi == '0));

    // R4
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (!step.valid && !drv_off) |=> (bad_q && g_q == '0));

endmodule

// File: rtl/hall_gate_sel.sv
module hall_gate_sel
    import hgs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALL_W-1:0] hall_in,
    input  logic              dir_fwd,
    input  logic              decay_slow,
    input  logic              sync_rect,
    input  logic              brake_n,
    input  logic              drv_off,
    input  logic              pwm_on,
    input  logic              coast_req,
    output logic [NUM_PH-1:0] gate_hi,
    output logic [NUM_PH-1:0] gate_lo,
    output logic              hall_bad,
    output logic              hall_edge
);
    logic [HALL_W-1:0] code_s;
    step_t             step;
    gates_t            g_q;

    hgs_hall_sync #(.W(HALL_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .din    (hall_in),
        .code   (code_s),
        .change (hall_edge)
    );

    hgs_step_decode dec_i (
        .code (code_s),
        .fwd  (dir_fwd),
        .step (step)
    );

    hgs_gate_mux mux_i (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .decay_slow (decay_slow),
        .sync_rect  (sync_rect),
        .brake_n    (brake_n),
        .drv_off    (drv_off),
        .pwm_on     (pwm_on),
        .coast_req  (coast_req),
        .g_q        (g_q),
        .bad_q      (hall_bad)
    );

    assign gate_hi = g_q.hi;
    assign gate_lo = g_q.lo;

endmodule

// File: tb/hall_gate_sel_tb_top.sv
module hall_gate_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hall_in = 3'b101;
    logic       dir_fwd = 1'b1;
    logic       decay_slow = 1'b0;
    logic       sync_rect = 1'b0;
    logic       brake_n = 1'b1;
    logic       drv_off = 1'b0;
    logic       pwm_on = 1'b1;
    logic       coast_req = 1'b0;
    logic [2:0] gate_hi;
    logic [2:0] gate_lo;
    logic       hall_bad;
    logic       hall_edge;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R12";
    bit    started = 0;

    always #4 clk = ~clk;

    hall_gate_sel dut_i (
        .clk        (clk),
        .rst        (rst),
        .hall_in    (hall_in),
        .dir_fwd    (dir_fwd),
        .decay_slow (decay_slow),
        .sync_rect  (sync_rect),
        .brake_n    (brake_n),
        .drv_off    (drv_off),
        .pwm_on     (pwm_on),
        .coast_req  (coast_req),
        .gate_hi    (gate_hi),
        .gate_lo    (gate_lo),
        .hall_bad   (hall_bad),
        .hall_edge  (hall_edge)
    );

    // reference model state: history of sampled sensor values
    int         hist[$];
    logic [2:0] exp_hi = '0;
    logic [2:0] exp_lo = '0;
    logic       exp_bad = 1'b0;

    function automatic int hist_at(int back);
        if (hist.size() > back) return hist[hist.size()-1-back];
        return 0;
    endfunction

    // phase numbers: 0=A 1=B 2=C; -1 = illegal
    task automatic ref_pair(input int code, input bit fwd, output int hp, output int lp);
        int a, b;
        case (code)
            5: begin a = 0; b = 2; end
            4: begin a = 1; b = 2; end
            6: begin a = 1; b = 0; end
            2: begin a = 2; b = 0; end
            3: begin a = 2; b = 1; end
            1: begin a = 0; b = 1; end
            default: begin a = -1; b = -1; end
        endcase
        if (fwd) begin hp = a; lp = b; end
        else     begin hp = b; lp = a; end
    endtask

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            hist.delete();
            exp_hi = '0; exp_lo = '0; exp_bad = 1'b0;
        end else begin
            int code, hp, lp;
            code = hist_at(1);  // value two samples deep = synchronized code
            ref_pair(code, dir_fwd, hp, lp);
            exp_hi = '0; exp_lo = '0;
            exp_bad = (hp < 0);
            if (drv_off) exp_bad = 1'b0;
            else if (coast_req || hp < 0) ;
            else if (!brake_n) exp_lo = 3'b111;
            else if (pwm_on) begin exp_hi[hp] = 1'b1; exp_lo[lp] = 1'b1; end
            else if (decay_slow && !sync_rect) exp_lo[lp] = 1'b1;
            else if (!decay_slow && sync_rect) begin exp_hi[lp] = 1'b1; exp_lo[hp] = 1'b1; end
            else if (decay_slow && sync_rect) begin exp_lo[lp] = 1'b1; exp_lo[hp] = 1'b1; end
            hist.push_back(int'(hall_in));
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    always @(negedge clk) begin
        if (started) begin
            logic exp_edge;
            exp_edge = rst ? 1'b0 : (hist_at(1) != hist_at(2));
            checks++;
            if ({gate_hi, gate_lo, hall_bad, hall_edge} !== {exp_hi, exp_lo, exp_bad, exp_edge}) begin
                errors++;
                $display("FAIL %s hi/lo/bad/edge act=%b_%b_%b_%b exp=%b_%b_%b_%b at %0t",
                         cur_req, gate_hi, gate_lo, hall_bad, hall_edge,
                         exp_hi, exp_lo, exp_bad, exp_edge, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spin(input bit fwd, input int hold);
        int seq[6] = '{5, 4, 6, 2, 3, 1};
        dir_fwd = fwd;
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < 6; i++) begin
                hall_in = 3'(seq[i]);
                step(hold);
            end
    endtask

    initial begin
        step(4);
        cur_req = "R12";
        checks++;
        if ({gate_hi, gate_lo, hall_bad, hall_edge} !== 8'b0) begin
            errors++;
            $display("FAIL R12 reset outputs act=%b exp=%b",
                     {gate_hi, gate_lo, hall_bad, hall_edge}, 8'b0);
        end
        rst = 1'b0;
        step(4);

        cur_req = "R2"; spin(1'b1, 4);
        cur_req = "R3"; spin(1'b0, 4);
        cur_req = "R1"; spin(1'b1, 1);
        step(4);

        cur_req = "R4";
        hall_in = 3'b000; step(5);
        hall_in = 3'b111; step(5);
        brake_n = 1'b0;   step(4);
        brake_n = 1'b1;   hall_in = 3'b011; step(4);

        pwm_on = 1'b0;
        cur_req = "R5"; decay_slow = 1; sync_rect = 0; spin(1'b1, 3); spin(1'b0, 3);
        cur_req = "R6"; decay_slow = 0; sync_rect = 0; spin(1'b1, 3); spin(1'b0, 3);
        cur_req = "R7"; decay_slow = 0; sync_rect = 1; spin(1'b1, 3); spin(1'b0, 3);
        cur_req = "R8"; decay_slow = 1; sync_rect = 1; spin(1'b1, 3); spin(1'b0, 3);

        cur_req = "R9"; brake_n = 1'b0;
        spin(1'b1, 2);
        pwm_on = 1'b1; spin(1'b0, 2);

        cur_req = "R10"; coast_req = 1'b1; step(5);
        brake_n = 1'b1; step(5);
        coast_req = 1'b0; step(4);

        cur_req = "R11"; drv_off = 1'b1; coast_req = 1'b1; brake_n = 1'b0; step(4);
        hall_in = 3'b000; step(5);
        coast_req = 1'b0; brake_n = 1'b1; hall_in = 3'b110; step(5);
        drv_off = 1'b0; step(4);

        cur_req = "R13";
        for (int i = 0; i < 400; i++) begin
            logic [9:0] r;
            r = 10'($urandom);
            hall_in    = r[2:0];
            dir_fwd    = r[3];
            decay_slow = r[4];
            sync_rect  = r[5];
            brake_n    = r[6] | r[9];
            pwm_on     = r[7];
            coast_req  = (r[8] & r[9]);
            drv_off    = (r[8:6] == 3'b111);
            step(1);
        end
        step(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule